// File: doc/BRIEF.md
# Protected memory sequential read controller

This block is the byte-level transaction engine in front of a small serial EEPROM that guards some of its contents. A bit-level serial front end hands it start and stop events, received bytes and read-byte strobes. The block checks the device-address byte against a programmable 7-bit address and reports ACK or NACK. For a write it takes two address bytes, most significant first, and then data bytes. For a read it returns one byte per strobe. A single address pointer serves both directions, so a read with no address phase continues where the last write stopped.

On every byte read, the block checks the pointer against the end of user memory (0x0FFF) and against a 16-bit read-protection map that has one bit per 256-byte zone. A byte that fails either check is returned as 0xFF and sets a sticky error bit. That bit stays set for the rest of the read, however long the read is. A write-enable flag is raised and lowered only by dedicated command pulses and by the end of a write, never by a read. The memory array sits outside the block behind a synchronous one-cycle-latency port.

Top module: `prot_seqrd_ctrl`

## Requirements
- R1: After reset, err_o, wen_o, ack_vld_o and rd_vld_o are 0 and the pointer is 0x0000, so a read with no address phase returns the byte at address 0.
- R2: A device byte (bits 7:1 address, bit 0 = 1 for read) produces ack_vld_o=1 in the next cycle. In that cycle ack_o=1 only when all 7 bits equal dev_addr_i. On a mismatch, including a match of the upper six bits only, ack_o=0 and all bytes and strobes are ignored until the next start.
- R3: After an acknowledged write device byte, the next two bytes load the pointer (high byte first). Each following data byte is written to the pointer address when wen_o=1 and that address is at most 0x0FFF.
- R4: During a write, the pointer advances within its 32-byte page: bits 4:0 wrap and the upper bits are kept.
- R5: A read with no address phase after a write returns the byte that follows the last byte written.
- R6: A rd_strobe_i pulse in cycle t gives rd_vld_o=1 with the data in cycle t+1 only. After each byte read the pointer moves up by one.
- R7: Each byte read from an address above 0x0FFF returns 0xFF and sets err_o=1.
- R8: Map bit z set to 1 protects addresses z*256 to z*256+255. A byte read there returns 0xFF and sets err_o=1. Readable bytes before it return their stored data with err_o=0.
- R9: Once set, err_o stays 1 for any number of bytes read. It is cleared only by the next matching device byte.
- R10: The pointer saturates at 0xFFFF on reads and does not wrap to 0x0000.
- R11: A wren_cmd_i pulse sets wen_o. A wrdis_cmd_i pulse, or a stop or start that ends a write in which at least one byte was written, clears it. When a clear and an enable fall in the same cycle, the clear wins.
- R12: Reads of any address, legal or not, leave wen_o unchanged.
- R13: Data bytes sent while wen_o=0 leave memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_addr_i | input | 7 | Programmable device address |
| prot_map_i | input | 16 | Read protection, one bit per 256-byte zone, 1 = protected |
| start_i | input | 1 | Start event pulse |
| stop_i | input | 1 | Stop event pulse |
| byte_vld_i | input | 1 | Received byte valid |
| byte_i | input | 8 | Received byte |
| rd_strobe_i | input | 1 | Request for the next read byte |
| wren_cmd_i | input | 1 | Write-enable command pulse |
| wrdis_cmd_i | input | 1 | Write-disable command pulse |
| ack_vld_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| rd_vld_o | output | 1 | Read byte valid |
| rd_data_o | output | 8 | Read byte |
| err_o | output | 1 | Sticky error status bit |
| wen_o | output | 1 | Write-enable flag |
| mem_addr_o | output | 12 | Memory byte address |
| mem_re_o | output | 1 | Memory read enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after mem_re_o |

## Verification
The write-enable flag can receive a set and a clear in the same cycle. This happens when an enable command arrives in the cycle whose stop ends a write, and when enable and disable pulses coincide. The bench drives both cases in one cycle and requires the flag to read 0 afterwards. A second collision pairs a read of an illegal address with a write-enable flag that is set. Here the error bit must rise while the flag holds its value.

// File: rtl/prot_seqrd_pkg.sv
// Shared types for the protected sequential read controller.
// Assumes nothing beyond the 1800-2017 enum support.
package prot_seqrd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDATA,
        ST_RDATA
    } psr_state_e;
endpackage

// File: rtl/psr_devmatch.sv
// Device-address comparator with a registered acknowledge decision.
// Compares all DEV_W address bits of the device byte; bit 0 carries direction.
// Assumes capture_i is high for exactly the cycle the device byte is accepted.
module psr_devmatch #(
    parameter int DEV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [DEV_W:0]   byte_i,
    input  logic [DEV_W-1:0] dev_addr_i,
    output logic             match_o,
    output logic             rd_dir_o,
    output logic             ack_vld_o,
    output logic             ack_o
);
    logic ack_vld_q;
    logic ack_q;

    // full-width compare of the address field
    always_comb begin
        match_o  = (byte_i[DEV_W:1] == dev_addr_i);
        rd_dir_o = byte_i[0];
    end

    // register the decision for the cycle after the byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_vld_q <= 1'b0;
            ack_q     <= 1'b0;
        end else begin
            ack_vld_q <= capture_i;
            ack_q     <= capture_i && match_o;
        end
    end

    assign ack_vld_o = ack_vld_q;
    assign ack_o     = ack_q;

    // R2
    ack_full_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (ack_vld_o && (ack_o == ($past(byte_i[DEV_W:1]) == $past(dev_addr_i)))));

    // R2
    ack_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ack_vld_o);
endmodule

// File: rtl/psr_access_chk.sv
// Per-byte read permission check: the end of user memory and the zone map.
// A byte is legal when it lies inside user memory and its zone bit is 0.
// Assumes MEM_BYTES and ZONE_BYTES are powers of two, ZONE_BYTES <= MEM_BYTES.
module psr_access_chk #(
    parameter int ADDR_W     = 16,
    parameter int MEM_BYTES  = 4096,
    parameter int ZONE_BYTES = 256,
    localparam int MEM_AW    = $clog2(MEM_BYTES),
    localparam int ZONE_SH   = $clog2(ZONE_BYTES),
    localparam int NZONES    = MEM_BYTES / ZONE_BYTES,
    localparam int ZIDX_W    = (NZONES > 1) ? $clog2(NZONES) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NZONES-1:0] prot_map_i,
    output logic              oob_o,
    output logic              prot_o,
    output logic              legal_o
);
    logic [ZIDX_W-1:0] zone_idx;

    // out-of-range decode, present only when the pointer is wider than memory
    generate
        if (ADDR_W > MEM_AW) begin : g_oob
            always_comb oob_o = (addr_i[ADDR_W-1:MEM_AW] != '0);
        end else begin : g_no_oob
            always_comb oob_o = 1'b0;
        end
    endgenerate

    // zone index selection, a single zone needs no index bits
    generate
        if (NZONES > 1) begin : g_zidx
            always_comb zone_idx = addr_i[MEM_AW-1:ZONE_SH];
        end else begin : g_zone1
            always_comb zone_idx = '0;
        end
    endgenerate

    // combine the two checks
    always_comb begin
        prot_o  = prot_map_i[zone_idx];
        legal_o = !oob_o && !prot_o;
    end
endmodule

// File: rtl/psr_pointer.sv
// Shared byte address pointer for writes and reads.
// Load wins over read advance, which wins over page-wrapping write advance.
// Reads saturate at all-ones; writes wrap inside a PAGE_BYTES page.
module psr_pointer #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 32,
    localparam int PG_SH     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              rd_inc_i,
    input  logic              wr_inc_i,
    output logic [ADDR_W-1:0] ptr_o
);
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] rd_next;
    logic [ADDR_W-1:0] wr_next;

    // candidate next values for both advance modes
    always_comb begin
        rd_next = (ptr_q == '1) ? ptr_q : ptr_q + ADDR_W'(1);
        wr_next = {ptr_q[ADDR_W-1:PG_SH], ptr_q[PG_SH-1:0] + PG_SH'(1)};
    end

    // pointer register with fixed priority
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr_q <= '0;
        else if (load_i)   ptr_q <= load_val_i;
        else if (rd_inc_i) ptr_q <= rd_next;
        else if (wr_inc_i) ptr_q <= wr_next;
    end

    assign ptr_o = ptr_q;

    // R10
    ptr_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_inc_i && !load_i && (ptr_q == '1)) |=> (ptr_q == '1));

    // R4
    page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_inc_i && !rd_inc_i && !load_i) |=> $stable(ptr_q[ADDR_W-1:PG_SH]));
endmodule

// File: rtl/psr_status.sv
// Status register: sticky error bit and write-enable flag.
// The error clear is applied before the set; on the flag a clear beats a set.
// Assumes the caller never asserts the error set and clear together.
module psr_status (
    input  logic clk,
    input  logic rst_n,
    input  logic err_set_i,
    input  logic err_clr_i,
    input  logic wen_set_i,
    input  logic wen_clr_i,
    output logic err_o,
    output logic wen_o
);
    logic err_q;
    logic wen_q;

    // sticky error bit
    always_ff @(posedge clk) begin
        if (!rst_n)         err_q <= 1'b0;
        else if (err_clr_i) err_q <= 1'b0;
        else if (err_set_i) err_q <= 1'b1;
    end

    // write-enable flag, clear dominant
    always_ff @(posedge clk) begin
        if (!rst_n)         wen_q <= 1'b0;
        else if (wen_clr_i) wen_q <= 1'b0;
        else if (wen_set_i) wen_q <= 1'b1;
    end

    assign err_o = err_q;
    assign wen_o = wen_q;

    // R11
    wen_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wen_o) |-> $past(wen_set_i));

    // R11
    wen_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wen_clr_i |=> !wen_o);
endmodule

// File: rtl/prot_seqrd_ctrl.sv
// Top of the protected sequential read controller.
// Sequences device, address and data bytes and owns the read return path.
// It drives a synchronous memory with one cycle of read latency.
// A start outranks a stop, and both outrank a byte or a strobe in the same cycle.
module prot_seqrd_ctrl
    import prot_seqrd_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int MEM_BYTES  = 4096,
    parameter int ZONE_BYTES = 256,
    parameter int PAGE_BYTES = 32,
    parameter int DEV_W      = 7,
    localparam int MEM_AW    = $clog2(MEM_BYTES),
    localparam int NZONES    = MEM_BYTES / ZONE_BYTES,
    localparam int BYTE_W    = DEV_W + 1,
    localparam int HI_W      = ADDR_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  dev_addr_i,
    input  logic [NZONES-1:0] prot_map_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              rd_strobe_i,
    input  logic              wren_cmd_i,
    input  logic              wrdis_cmd_i,
    output logic              ack_vld_o,
    output logic              ack_o,
    output logic              rd_vld_o,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              err_o,
    output logic              wen_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    input  logic [BYTE_W-1:0] mem_rdata_i
);
    psr_state_e        state_q, state_d;
    logic [HI_W-1:0]   ahi_q;
    logic              wrote_q;
    logic              rd_pend_q;
    logic              rd_legal_q;

    logic              evt_free;
    logic              byte_ok;
    logic              dev_byte;
    logic              match;
    logic              rd_dir;
    logic              ptr_load;
    logic              wr_fire;
    logic              wr_do;
    logic              rd_fire;
    logic [ADDR_W-1:0] ptr;
    logic              oob;
    logic              prot;
    logic              legal;
    logic              err_set;
    logic              err_clr;
    logic              wen_clr;

    // qualify bytes and strobes: none is taken in a cycle with a start or stop
    always_comb begin
        evt_free = !start_i && !stop_i;
        byte_ok  = byte_vld_i && evt_free;
        dev_byte = byte_ok && (state_q == ST_DEV);
        ptr_load = byte_ok && (state_q == ST_ALO);
        wr_fire  = byte_ok && (state_q == ST_WDATA);
        wr_do    = wr_fire && wen_o && !oob;
        rd_fire  = rd_strobe_i && evt_free && (state_q == ST_RDATA);
    end

    psr_devmatch #(
        .DEV_W(DEV_W)
    ) u_devmatch (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (dev_byte),
        .byte_i     (byte_i),
        .dev_addr_i (dev_addr_i),
        .match_o    (match),
        .rd_dir_o   (rd_dir),
        .ack_vld_o  (ack_vld_o),
        .ack_o      (ack_o)
    );

    psr_pointer #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_pointer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ptr_load),
        .load_val_i ({ahi_q, byte_i}),
        .rd_inc_i   (rd_fire),
        .wr_inc_i   (wr_fire),
        .ptr_o      (ptr)
    );

    psr_access_chk #(
        .ADDR_W     (ADDR_W),
        .MEM_BYTES  (MEM_BYTES),
        .ZONE_BYTES (ZONE_BYTES)
    ) u_access (
        .addr_i     (ptr),
        .prot_map_i (prot_map_i),
        .oob_o      (oob),
        .prot_o     (prot),
        .legal_o    (legal)
    );

    // status causes: errors from reads only, the flag from commands and write end
    always_comb begin
        err_set = rd_fire && !legal;
        err_clr = dev_byte && match;
        wen_clr = wrdis_cmd_i || ((start_i || stop_i) && wrote_q);
    end

    psr_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_set_i (err_set),
        .err_clr_i (err_clr),
        .wen_set_i (wren_cmd_i),
        .wen_clr_i (wen_clr),
        .err_o     (err_o),
        .wen_o     (wen_o)
    );

    // transaction phase sequencing
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_DEV;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end else if (byte_vld_i) begin
            case (state_q)
                ST_DEV:  state_d = match ? (rd_dir ? ST_RDATA : ST_AHI) : ST_IDLE;
                ST_AHI:  state_d = ST_ALO;
                ST_ALO:  state_d = ST_WDATA;
                default: state_d = state_q;
            endcase
        end
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // high address byte holding register
    always_ff @(posedge clk) begin
        if (!rst_n)                             ahi_q <= '0;
        else if (byte_ok && state_q == ST_AHI) ahi_q <= byte_i[HI_W-1:0];
    end

    // tracks whether the current write stored at least one byte
    always_ff @(posedge clk) begin
        if (!rst_n)                 wrote_q <= 1'b0;
        else if (start_i || stop_i) wrote_q <= 1'b0;
        else if (wr_do)             wrote_q <= 1'b1;
    end

    // read return pipeline, aligned with the memory latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q  <= 1'b0;
            rd_legal_q <= 1'b0;
        end else begin
            rd_pend_q  <= rd_fire;
            rd_legal_q <= legal;
        end
    end

    // memory port and read byte outputs
    always_comb begin
        mem_addr_o  = ptr[MEM_AW-1:0];
        mem_re_o    = rd_fire && legal;
        mem_we_o    = wr_do;
        mem_wdata_o = byte_i;
        rd_vld_o    = rd_pend_q;
        rd_data_o   = rd_legal_q ? mem_rdata_i : '1;
    end

    // R7
    oob_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && oob) |=> (rd_vld_o && (rd_data_o == '1) && err_o));

    // R8
    prot_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && prot) |=> (rd_vld_o && (rd_data_o == '1) && err_o));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !(byte_vld_i && state_q == ST_DEV)) |=> err_o);

    // R12
    read_keeps_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDATA && !wren_cmd_i && !wrdis_cmd_i) |=> $stable(wen_o));

    // R13
    write_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> wen_o);

    // R6
    rd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld_o |-> $past(rd_strobe_i));
endmodule

// File: tb/prot_seqrd_ctrl_tb.sv
// Self-checking bench: device-address table loop, then directed tests.
module prot_seqrd_ctrl_tb;
    localparam int MEM_BYTES = 4096;
    localparam int MEM_AW    = $clog2(MEM_BYTES);
    localparam logic [7:0] DEVW = 8'hA0;
    localparam logic [7:0] DEVR = 8'hA1;
    // {device byte, expected ack}; device address is 7'h50
    localparam logic [8:0] ACK_TAB [6] = '{
        {8'hA0, 1'b1}, {8'hA1, 1'b1}, {8'hA2, 1'b0},
        {8'hA3, 1'b0}, {8'h20, 1'b0}, {8'hE1, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [6:0]        dev_addr = 7'h50;
    logic [15:0]       prot_map = '0;
    logic              start = 1'b0, stop = 1'b0, bvld = 1'b0, rstb = 1'b0;
    logic              wren = 1'b0, wrdis = 1'b0;
    logic [7:0]        bdat = '0;
    logic              ack_vld, ack, rd_vld, err, wen, mem_re, mem_we;
    logic [7:0]        rd_data, mem_wdata;
    logic [7:0]        mem_rdata = '0;
    logic [MEM_AW-1:0] mem_addr;
    logic [7:0]        ram [MEM_BYTES];
    int                n_tests = 0;
    int                n_fail = 0;
    logic [7:0]        rv;
    logic              re;

    always #4 clk = ~clk;

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // memory model with one cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) ram[i] <= init_val(i);
        end else begin
            if (mem_re) mem_rdata <= ram[mem_addr];
            if (mem_we) ram[mem_addr] <= mem_wdata;
        end
    end

    prot_seqrd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .dev_addr_i(dev_addr), .prot_map_i(prot_map),
        .start_i(start), .stop_i(stop), .byte_vld_i(bvld), .byte_i(bdat),
        .rd_strobe_i(rstb), .wren_cmd_i(wren), .wrdis_cmd_i(wrdis),
        .ack_vld_o(ack_vld), .ack_o(ack), .rd_vld_o(rd_vld), .rd_data_o(rd_data),
        .err_o(err), .wen_o(wen), .mem_addr_o(mem_addr), .mem_re_o(mem_re),
        .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic p_start();
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    endtask
    task automatic p_stop();
        @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
    endtask
    task automatic p_wren();
        @(negedge clk); wren = 1'b1; @(negedge clk); wren = 1'b0;
    endtask
    task automatic p_wrdis();
        @(negedge clk); wrdis = 1'b1; @(negedge clk); wrdis = 1'b0;
    endtask
    task automatic send(input logic [7:0] b);
        @(negedge clk); bvld = 1'b1; bdat = b; @(negedge clk); bvld = 1'b0;
    endtask
    // one read byte; results sampled in the cycle after the strobe
    task automatic rd1(output logic [7:0] d, output logic e);
        @(negedge clk); rstb = 1'b1; @(negedge clk); rstb = 1'b0;
        d = rd_vld ? rd_data : 8'hxx;
        e = err;
    endtask
    task automatic set_ptr(input logic [15:0] a);
        p_start(); send(DEVW); send(a[15:8]); send(a[7:0]); p_stop();
    endtask
    task automatic begin_read();
        p_start(); send(DEVR);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 err", 16'(err), 0);
        chk("R1 wen", 16'(wen), 0);
        chk("R1 ack_vld", 16'(ack_vld), 0);
        chk("R1 rd_vld", 16'(rd_vld), 0);
        begin_read(); rd1(rv, re);
        chk("R1 ptr zero read", 16'(rv), 16'(init_val(0)));
        // R6 valid lasts one cycle
        @(negedge clk);
        chk("R6 rd_vld single", 16'(rd_vld), 0);
        p_stop();

        // R2 device address table
        for (int k = 0; k < 6; k++) begin
            p_start(); send(ACK_TAB[k][8:1]);
            chk("R2 ack_vld", 16'(ack_vld), 1);
            chk("R2 ack", 16'(ack), 16'(ACK_TAB[k][0]));
            p_stop();
        end
        // R2 after NACK strobes are ignored
        p_start(); send(8'hA3);
        @(negedge clk); rstb = 1'b1; @(negedge clk); rstb = 1'b0;
        chk("R2 ignored after nack", 16'(rd_vld), 0);
        p_stop();

        // R13 write without enable
        p_start(); send(DEVW); send(8'h00); send(8'h10); send(8'h11); p_stop();
        set_ptr(16'h0010); begin_read(); rd1(rv, re); p_stop();
        chk("R13 no write", 16'(rv), 16'(init_val(16'h10)));

        // R11 enable, R3 write burst, write end clears enable
        p_wren();
        chk("R11 wen set", 16'(wen), 1);
        p_start(); send(DEVW); send(8'h01); send(8'h00);
        send(8'hC1); send(8'hC2); send(8'hC3); p_stop();
        chk("R11 wen cleared by write end", 16'(wen), 0);
        set_ptr(16'h0100); begin_read();
        rd1(rv, re); chk("R3 byte0", 16'(rv), 16'h00C1);
        rd1(rv, re); chk("R3 byte1", 16'(rv), 16'h00C2);
        rd1(rv, re); chk("R3 byte2", 16'(rv), 16'h00C3);
        p_stop();

        // R5 current address read follows the last written byte
        p_wren();
        p_start(); send(DEVW); send(8'h02); send(8'h00); send(8'hD0); send(8'hD1);
        p_start();
        chk("R11 cleared by restart", 16'(wen), 0);
        send(DEVR); rd1(rv, re); p_stop();
        chk("R5 next byte", 16'(rv), 16'(init_val(16'h202)));

        // R4 page wrap
        p_wren();
        p_start(); send(DEVW); send(8'h02); send(8'h1E);
        send(8'hE0); send(8'hE1); send(8'hE2); send(8'hE3); p_stop();
        begin_read(); rd1(rv, re); p_stop();
        chk("R4 pointer after wrap", 16'(rv), 16'(init_val(16'h202)));
        set_ptr(16'h021E); begin_read();
        rd1(rv, re); chk("R4 0x21E", 16'(rv), 16'h00E0);
        rd1(rv, re); chk("R4 0x21F", 16'(rv), 16'h00E1);
        rd1(rv, re); chk("R4 0x220 untouched", 16'(rv), 16'(init_val(16'h220)));
        p_stop();
        set_ptr(16'h0200); begin_read();
        rd1(rv, re); chk("R4 0x200", 16'(rv), 16'h00E2);
        rd1(rv, re); chk("R4 0x201", 16'(rv), 16'h00E3);
        p_stop();

        // R12 illegal read with enable set
        p_wren();
        set_ptr(16'h0FFF); begin_read();
        rd1(rv, re); rd1(rv, re);
        chk("R12 wen kept", 16'(wen), 1);
        chk("R7 err on illegal", 16'(re), 1);
        p_stop();
        p_wrdis();
        chk("R11 wen disabled", 16'(wen), 0);

        // R7 end of memory, R9 long read
        set_ptr(16'h0FFE); begin_read();
        rd1(rv, re); chk("R7 0xFFE", 16'(rv), 16'(init_val(16'hFFE)));
        chk("R7 err still 0", 16'(re), 0);
        rd1(rv, re); chk("R7 0xFFF", 16'(rv), 16'(init_val(16'hFFF)));
        rd1(rv, re); chk("R7 beyond data", 16'(rv), 16'h00FF);
        chk("R7 beyond err", 16'(re), 1);
        bad = 0;
        for (int k = 0; k < 300; k++) begin
            rd1(rv, re);
            if (rv !== 8'hFF || re !== 1'b1) bad++;
        end
        chk("R9 sticky over 300 bytes", 16'(bad), 0);
        p_start(); send(DEVR);
        chk("R9 cleared by new command", 16'(err), 0);
        p_stop();

        // R8 protected zone 3
        prot_map = 16'h0008;
        set_ptr(16'h02FE); begin_read();
        rd1(rv, re); chk("R8 0x2FE", 16'(rv), 16'(init_val(16'h2FE)));
        rd1(rv, re); chk("R8 0x2FF", 16'(rv), 16'(init_val(16'h2FF)));
        chk("R8 err 0 before zone", 16'(re), 0);
        rd1(rv, re); chk("R8 0x300 masked", 16'(rv), 16'h00FF);
        chk("R8 err in zone", 16'(re), 1);
        p_stop();
        prot_map = 16'h0000;
        set_ptr(16'h0300); begin_read();
        rd1(rv, re); chk("R8 unprotected again", 16'(rv), 16'(init_val(16'h300)));
        chk("R8 err 0 when unprotected", 16'(re), 0);
        p_stop();

        // R10 saturation
        set_ptr(16'hFFFE); begin_read();
        bad = 0;
        for (int k = 0; k < 5; k++) begin
            rd1(rv, re);
            if (rv !== 8'hFF) bad++;
        end
        chk("R10 no wrap", 16'(bad), 0);
        p_stop();

        // R11 stop ending a write meets an enable in the same cycle
        p_wren();
        p_start(); send(DEVW); send(8'h04); send(8'h00); send(8'h77);
        @(negedge clk); stop = 1'b1; wren = 1'b1;
        @(negedge clk); stop = 1'b0; wren = 1'b0;
        chk("R11 completion beats enable", 16'(wen), 0);
        @(negedge clk); wren = 1'b1; wrdis = 1'b1;
        @(negedge clk); wren = 1'b0; wrdis = 1'b0;
        chk("R11 disable beats enable", 16'(wen), 0);
        set_ptr(16'h0400); begin_read(); rd1(rv, re); p_stop();
        chk("R3 single byte write", 16'(rv), 16'h0077);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule